// File: doc/BRIEF.md
# GPIO Port Data Controller

This block manages the data side of one general-purpose I/O port of up to sixteen pins. Software reaches it through a small register bus with address, write enable, write data and read data. Four stored configuration words set, pin by pin, the driven level, the tri-state drive enable, whether the pin's sampled level is passed inward, and the pull-up request. A fifth address accepts write-only toggle masks. Writing a mask inverts the selected driven bits in one bus write, and the other bits keep their values.

Pin levels enter through a two-stage synchronizer. Each synchronized level is then masked by its input-enable bit. The masked vector is registered, and it feeds two places: the read port, and an output for a separate edge-detect and interrupt block. The analog pull-up device and the pad cell are outside this block. It only produces the pad-side control vectors, and every one of them comes straight from a flip-flop.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the output data, drive enable, input enable and pull-up words are all 0. pad_out, pad_oe, pad_pu, edge_src and bus_rdata are all 0.
- R2: A write to address 0 stores the output data word, and a write to address 1 stores the drive-enable word. pad_oe shows the drive-enable word from the clock edge of the write onward. Each bit acts only on its own pin.
- R3: pad_out bit i equals output data bit i AND drive-enable bit i. A pin that is not driven shows 0 on pad_out.
- R4: A write to address 4 inverts every output data bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their values. The change appears on the same clock edge as the write.
- R5: A read of address 4 returns 0.
- R6: pad_pu bit i is 1 exactly when pull-up bit i (address 3) is 1 and drive-enable bit i is 0.
- R7: With input-enable bit i (address 2) set, edge_src bit i follows pad_in bit i three clock edges later. With the bit clear, edge_src bit i is 0. A read of address 5 returns edge_src.
- R8: Writes to addresses 5, 6 and 7 change nothing. Reads of addresses 6 and 7 return 0.
- R9: bus_rdata is registered. It presents the word selected by bus_addr at the clock edge after the address is applied. Reads of addresses 0 to 3 return the stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Registered read data |
| pad_in | input | N | Raw pin levels |
| pad_out | output | N | Level driven to each pin |
| pad_oe | output | N | Tri-state drive enable per pin |
| pad_pu | output | N | Pull-up request per pin |
| edge_src | output | N | Gated, synchronized levels for the interrupt block |

## Verification
A corrupted stored word shows up at the pad vectors on the clock edge after the write that should have set it: in pad_out, pad_oe or pad_pu. The readback one cycle later shows it as well. A toggle applied to the wrong bits, or one that also touches enable state, shows as a pad_out mismatch right after the mask write. A fault in the synchronizer or in the input gating shows on edge_src three edges after a pin change, and on the input readback one edge after that.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_DATA   = 3'd0,
    RA_DRIVE  = 3'd1,
    RA_INEN   = 3'd2,
    RA_PULL   = 3'd3,
    RA_FLIP   = 3'd4,
    RA_LEVEL  = 3'd5,
    RA_RSVD6  = 3'd6,
    RA_RSVD7  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      data_q,
  output logic [N-1:0]      drive_q,
  output logic [N-1:0]      inen_q,
  output logic [N-1:0]      pull_q,
  output logic [N-1:0]      pad_out,
  output logic [N-1:0]      pad_oe,
  output logic [N-1:0]      pad_pu
);
  logic [N-1:0] data_n, drive_n, pull_n, flip_mask;

  always_comb begin
    data_n    = data_q;
    drive_n   = drive_q;
    pull_n    = pull_q;
    flip_mask = '0;
    if (we) begin
      case (reg_addr_e'(addr))
        RA_DATA:  data_n    = wdata;
        RA_DRIVE: drive_n   = wdata;
        RA_PULL:  pull_n    = wdata;
        RA_FLIP:  flip_mask = wdata;
        default:  ;
      endcase
    end
    data_n = data_n ^ flip_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      drive_q <= '0;
      inen_q  <= '0;
      pull_q  <= '0;
      pad_out <= '0;
      pad_oe  <= '0;
      pad_pu  <= '0;
    end else begin
      data_q  <= data_n;
      drive_q <= drive_n;
      pull_q  <= pull_n;
      if (we && reg_addr_e'(addr) == RA_INEN) inen_q <= wdata;
      pad_out <= data_n & drive_n;
      pad_oe  <= drive_n;
      pad_pu  <= pull_n & ~drive_n;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  input  logic [N-1:0]      pad_in,
  output logic [N-1:0]      pad_out,
  output logic [N-1:0]      pad_oe,
  output logic [N-1:0]      pad_pu,
  output logic [N-1:0]      edge_src
);
  logic [N-1:0] data_q, drive_q, inen_q, pull_q;
  logic [N-1:0] lvl_sync;
  logic [N-1:0] rd_mux;

  gpio_cfg_regs #(.N(N)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .data_q  (data_q),
    .drive_q (drive_q),
    .inen_q  (inen_q),
    .pull_q  (pull_q),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pad_pu  (pad_pu)
  );

  gpio_in_sync #(.W(N), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (lvl_sync)
  );

  for (genvar i = 0; i < N; i++) begin : g_gate
    always_ff @(posedge clk) begin
      if (rst) edge_src[i] <= 1'b0;
      else     edge_src[i] <= lvl_sync[i] & inen_q[i];
    end
  end

  always_comb begin
    case (reg_addr_e'(bus_addr))
      RA_DATA:  rd_mux = data_q;
      RA_DRIVE: rd_mux = drive_q;
      RA_INEN:  rd_mux = inen_q;
      RA_PULL:  rd_mux = pull_q;
      RA_LEVEL: rd_mux = edge_src;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
#(
  parameter int N = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] bus_addr,
  input logic              bus_we,
  input logic [N-1:0]      bus_wdata,
  input logic [N-1:0]      bus_rdata,
  input logic [N-1:0]      pad_in,
  input logic [N-1:0]      pad_out,
  input logic [N-1:0]      pad_oe,
  input logic [N-1:0]      pad_pu,
  input logic [N-1:0]      edge_src
);
  a_r3_undriven_low: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0);

  a_r6_no_pull_when_driven: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_oe) == '0);

  a_r4_flip_selected: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_we) && $past(bus_addr) == RA_FLIP && !$past(rst)) |->
      (pad_out == (($past(pad_out) ^ $past(bus_wdata)) & pad_oe)) && $stable(pad_oe));

  a_r5_flip_reads_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == RA_FLIP && !$past(rst)) |-> bus_rdata == '0);

  a_r7_level_from_pin: assert property (@(posedge clk) disable iff (rst)
    (edge_src & ~$past(pad_in, 3)) == '0);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.N(N)) u_chk (.*);

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
  localparam int N = 16;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, pad_pu, edge_src;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] m_data = '0, m_drive = '0, m_inen = '0, m_pull = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl #(.N(N)) u_gpio_port_ctrl (.*);

  function automatic logic [N-1:0] exp_out();  return m_data & m_drive; endfunction
  function automatic logic [N-1:0] exp_pull(); return m_pull & ~m_drive; endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    case (a)
      3'd0: m_data  = d;
      3'd1: m_drive = d;
      3'd2: m_inen  = d;
      3'd3: m_pull  = d;
      3'd4: m_data  = m_data ^ d;
      default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, output logic [N-1:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic check_pads(string tag);
    check({tag, " R3 pad_out"}, pad_out, exp_out());
    check({tag, " R2 pad_oe"}, pad_oe, m_drive);
    check({tag, " R6 pad_pu"}, pad_pu, exp_pull());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pad_out", pad_out, '0);
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_pu", pad_pu, '0);
    check("R1 edge_src", edge_src, '0);
    check("R1 rdata", bus_rdata, '0);
    rst = 1'b0;
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), v);
      check("R1 reg zero", v, '0);
    end

    // directed: pull-up only in input mode (R6), gating (R3)
    wr(3'd3, 16'hFFFF);
    check_pads("R6 all pull");
    wr(3'd1, 16'h00F0);
    check_pads("R6 drive masks pull");
    wr(3'd0, 16'hAAAA);
    check_pads("R3 gated data");
    rd(3'd0, v); check("R9 data readback", v, 16'hAAAA);
    rd(3'd1, v); check("R9 drive readback", v, 16'h00F0);

    // R4 toggle with full drive
    wr(3'd1, 16'hFFFF);
    wr(3'd4, 16'h0F0F);
    check("R4 toggle", pad_out, 16'hA5A5);
    wr(3'd4, 16'h0000);
    check("R4 zero mask", pad_out, 16'hA5A5);
    rd(3'd4, v); check("R5 flip reads 0", v, '0);

    // R8 reserved addresses
    wr(3'd5, 16'h1234);
    wr(3'd6, 16'hFFFF);
    wr(3'd7, 16'h5555);
    check_pads("R8 ignored");
    rd(3'd6, v); check("R8 rsvd6 reads 0", v, '0);
    rd(3'd7, v); check("R8 rsvd7 reads 0", v, '0);
    rd(3'd0, v); check("R8 data intact", v, m_data);

    // R7 input path
    wr(3'd2, 16'h00FF);
    @(negedge clk); pad_in = 16'hFFFF;
    @(negedge clk); check("R7 not yet", edge_src, '0);
    @(negedge clk); check("R7 still syncing", edge_src, '0);
    @(negedge clk); check("R7 third edge", edge_src, 16'h00FF);
    rd(3'd5, v); check("R7 level read", v, 16'h00FF);
    wr(3'd2, 16'h0000);
    repeat (4) @(negedge clk);
    check("R7 disabled reads 0", edge_src, '0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op = $urandom_range(0, 9);
      logic [N-1:0] d = N'($urandom);
      if (op < 8) begin
        wr(3'(op), d);
        check_pads("R2 random");
      end else if (op == 8) begin
        int a = $urandom_range(0, 7);
        logic [N-1:0] e;
        rd(3'(a), v);
        case (a)
          0: e = m_data; 1: e = m_drive; 2: e = m_inen; 3: e = m_pull;
          5: e = pad_in & m_inen; default: e = '0;
        endcase
        check("R9 random read", v, e);
      end else begin
        @(negedge clk); pad_in = d;
        repeat (4) @(negedge clk);
        check("R7 random level", edge_src, pad_in & m_inen);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule